// File: doc/BRIEF.md
# Pedestal Subtraction and Rescaling Stage

This block sits in the per-channel front end of a detector readout path. Each valid input cycle carries one 10-bit ADC sample together with the index of the strip it came from. The block looks up a baseline value (the pedestal) stored for that strip and subtracts it from the sample, which gives a signed 11-bit difference. A two-bit scale mode then reduces the difference to an 8-bit signed result. The result leaves the block two cycles after the sample entered, still tagged with its strip index.

The pedestal table holds one entry per strip. A simple host port writes and reads it. An optional tracking loop lets every stored pedestal follow slow baseline drift. A small per-strip error accumulator with k = 4 fractional bits sums the raw sample-minus-pedestal error. Whenever that sum reaches plus or minus half of 2^k, the pedestal moves one LSB toward the samples.

Two input bits control the stage. Subtraction can be switched off, and then the raw sample goes to the scaler. Tracking can be switched on or off independently of subtraction. The enable bits are taken in the cycle the sample is presented. The scale mode is taken one cycle later, when the result is formed.

Top module: `ped_sub_scale`

## Requirements
- R1: `outVld` equals `inVld` delayed by exactly two clock cycles. Every valid output carries the strip index of the sample that produced it, and outputs come out in input order.
- R2: With `pedEn` = 1, the difference is `inSample` minus the pedestal stored for `inStrip`, taken as an 11-bit two's-complement value.
- R3: With `pedEn` = 0, the sample zero-extended to 11 bits goes to the scaler in place of the difference.
- R4: With `scaleMode` = 0, the difference is saturated to the range -128..+127 and output as 8-bit two's complement (for example 0x80 for -1000 and 0x7F for +1023).
- R5: With `scaleMode` = 1, 2 or 3, the output is bits [8:1], [9:2] or [10:3] of the 11-bit difference, with no saturation.
- R6: After reset, `outVld` and `outData` are 0, and every pedestal and every accumulator is 0.
- R7: A host write (`hostWe` = 1) stores `hostWdata` at `hostAddr`. `hostRdata` shows the entry at `hostAddr` one cycle after the address is presented.
- R8: With `trackEn` = 0, valid samples never change a stored pedestal.
- R9: With `trackEn` = 1, each valid sample adds its raw error (sample minus pedestal, whatever `pedEn` is) to the strip's 4-bit signed accumulator. If the sum is 8 or more, the pedestal rises by one and the accumulator clears. If the sum is -8 or less, the pedestal falls by one and the accumulator clears. Otherwise the accumulator keeps the sum.
- R10: A host write to the strip that a tracking update targets in the same cycle wins. The pedestal takes the host value, and every host write clears that strip's accumulator.
- R11: A sample is corrected with the pedestal as it stood before its own tracking update. The next sample to the same strip, even in the very next cycle, sees the updated pedestal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inVld | input | 1 | Input sample valid |
| inSample | input | 10 | Unsigned ADC sample |
| inStrip | input | 5 | Strip index of the sample |
| pedEn | input | 1 | 1 = subtract pedestal |
| trackEn | input | 1 | 1 = pedestals follow baseline drift |
| scaleMode | input | 2 | 0 saturate, 1/2/3 drop 1/2/3 LSBs |
| hostWe | input | 1 | Host pedestal write strobe |
| hostAddr | input | 5 | Host pedestal table index |
| hostWdata | input | 10 | Host pedestal write value |
| hostRdata | output | 10 | Pedestal at hostAddr, one cycle later |
| outVld | output | 1 | Output valid |
| outData | output | 8 | Rescaled signed result |
| outStrip | output | 5 | Strip index of the result |

## Verification
The hardest state to reach from the ports is a host write landing on the same strip, in the same cycle, as a tracking update. The accumulator of that strip must already hold a partial sum, so that a lost clear would show later as an extra step. The stimulus first builds an accumulator value of 5 on one strip. It then presents a sample and a host write to that strip in the same cycle. Finally it sends a sample whose error of 7 would cause a step only if the old sum had survived. Back-to-back samples to one strip whose pedestal moves on every sample cover the read-before-update ordering. A long randomized tracking run compares the whole table against the bench model at the end.

// File: rtl/ped_pkg.sv
package ped_pkg;

  typedef enum logic [1:0] {
    SCALE_SAT   = 2'd0,
    SCALE_DROP1 = 2'd1,
    SCALE_DROP2 = 2'd2,
    SCALE_DROP3 = 2'd3
  } scale_mode_e;

  // Strobes from the control block to the datapath
  typedef struct packed {
    logic        capture;   // load the difference register
    logic        subEn;     // subtract pedestal on capture
    logic        emit;      // load the output register
    scale_mode_e mode;      // reduction applied on emit
  } stage_strobe_t;

endpackage

// File: rtl/ped_ctrl.sv
module ped_ctrl
  import ped_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inVld,
  input  logic          pedEn,
  input  logic          trackEn,
  input  logic [1:0]    scaleMode,
  output stage_strobe_t strobe,
  output logic          trackStep,
  output logic          outVld
);

  logic       vld1;
  logic [1:0] warm;   // cycles since reset, saturating, for the latency check

  always_comb begin
    strobe.capture = inVld;
    strobe.subEn   = pedEn;
    strobe.emit    = vld1;
    strobe.mode    = scale_mode_e'(scaleMode);
    trackStep      = inVld && trackEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld1   <= 1'b0;
      outVld <= 1'b0;
      warm   <= 2'd0;
    end else begin
      vld1   <= inVld;
      outVld <= vld1;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  // R1: fixed two-cycle valid latency
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd2) |-> (outVld == $past(inVld, 2)));

endmodule

// File: rtl/ped_table.sv
module ped_table #(
  parameter int STRIPS = 32,
  parameter int PED_W  = 10,
  parameter int FRAC_K = 4,
  localparam int IDX_W = $clog2(STRIPS),
  localparam int ERR_W = PED_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trackStep,
  input  logic [IDX_W-1:0] rdStrip,
  input  logic [PED_W-1:0] sample,
  input  logic             hostWe,
  input  logic [IDX_W-1:0] hostAddr,
  input  logic [PED_W-1:0] hostWdata,
  output logic [PED_W-1:0] pedOut,
  output logic [PED_W-1:0] hostRdata
);

  localparam logic signed [ERR_W-1:0] HALF     = ERR_W'(2 ** (FRAC_K - 1));
  localparam logic signed [ERR_W-1:0] NEG_HALF = -HALF;

  logic [STRIPS-1:0][PED_W-1:0]  pedMem;
  logic [STRIPS-1:0][FRAC_K-1:0] accMem;

  logic [FRAC_K-1:0]        accCur;
  logic signed [ERR_W-1:0]  errVal;
  logic signed [ERR_W-1:0]  accExt;
  logic signed [ERR_W-1:0]  accSum;
  logic                     stepUp;
  logic                     stepDn;
  logic [PED_W-1:0]         nextPed;
  logic [FRAC_K-1:0]        nextAcc;
  logic                     collide;

  always_comb begin
    pedOut  = pedMem[rdStrip];
    accCur  = accMem[rdStrip];
    errVal  = $signed({2'b00, sample}) - $signed({2'b00, pedOut});
    accExt  = {{(ERR_W - FRAC_K){accCur[FRAC_K-1]}}, accCur};
    accSum  = accExt + errVal;
    stepUp  = (accSum >= HALF);
    stepDn  = (accSum <= NEG_HALF);
    nextPed = stepUp ? pedOut + PED_W'(1) :
              stepDn ? pedOut - PED_W'(1) : pedOut;
    nextAcc = (stepUp || stepDn) ? '0 : accSum[FRAC_K-1:0];
    collide = hostWe && (hostAddr == rdStrip);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pedMem    <= '0;
      accMem    <= '0;
      hostRdata <= '0;
    end else begin
      hostRdata <= pedMem[hostAddr];
      if (trackStep && !collide) begin
        pedMem[rdStrip] <= nextPed;
        accMem[rdStrip] <= nextAcc;
      end
      if (hostWe) begin
        pedMem[hostAddr] <= hostWdata;
        accMem[hostAddr] <= '0;
      end
    end
  end

  // R10: the host value lands, whatever tracking wanted
  a_r10_host_wins: assert property (@(posedge clk) disable iff (!rstN)
    hostWe |=> (pedMem[$past(hostAddr)] == $past(hostWdata)));

  // R8: no tracking step and no host write leaves the table untouched
  a_r8_table_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!trackStep && !hostWe) |=> $stable(pedMem));

  // R9: a tracking update moves a pedestal by at most one LSB
  a_r9_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    (trackStep && !collide) |=>
      ((pedMem[$past(rdStrip)] == $past(pedOut)) ||
       (pedMem[$past(rdStrip)] == $past(pedOut) + PED_W'(1)) ||
       (pedMem[$past(rdStrip)] == $past(pedOut) - PED_W'(1))));

endmodule

// File: rtl/ped_datapath.sv
module ped_datapath
  import ped_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int OUT_W    = 8,
  parameter int IDX_W    = 5,
  localparam int DIFF_W  = SAMPLE_W + 1,
  localparam int DROP_N  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  stage_strobe_t       strobe,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [IDX_W-1:0]    strip,
  input  logic [SAMPLE_W-1:0] ped,
  output logic [OUT_W-1:0]    outData,
  output logic [IDX_W-1:0]    outStrip
);

  localparam logic signed [DIFF_W-1:0] SAT_HI = DIFF_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [DIFF_W-1:0] SAT_LO = -SAT_HI - DIFF_W'(1);

  logic signed [DIFF_W-1:0] diffNext;
  logic signed [DIFF_W-1:0] diffQ;
  logic [IDX_W-1:0]         stripQ;
  logic [OUT_W-1:0]         satVal;
  logic [OUT_W-1:0]         dropped [1:DROP_N];
  logic [OUT_W-1:0]         scaled;

  always_comb begin
    if (strobe.subEn)
      diffNext = $signed({1'b0, sample}) - $signed({1'b0, ped});
    else
      diffNext = $signed({1'b0, sample});
  end

  // One candidate per LSB-dropping mode
  for (genvar k = 1; k <= DROP_N; k++) begin : g_drop
    assign dropped[k] = diffQ[OUT_W - 1 + k : k];
  end

  always_comb begin
    if (diffQ > SAT_HI)      satVal = SAT_HI[OUT_W-1:0];
    else if (diffQ < SAT_LO) satVal = SAT_LO[OUT_W-1:0];
    else                     satVal = diffQ[OUT_W-1:0];
    case (strobe.mode)
      SCALE_SAT:   scaled = satVal;
      SCALE_DROP1: scaled = dropped[1];
      SCALE_DROP2: scaled = dropped[2];
      default:     scaled = dropped[3];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diffQ    <= '0;
      stripQ   <= '0;
      outData  <= '0;
      outStrip <= '0;
    end else begin
      if (strobe.capture) begin
        diffQ  <= diffNext;
        stripQ <= strip;
      end
      if (strobe.emit) begin
        outData  <= scaled;
        outStrip <= stripQ;
      end
    end
  end

  // R4: saturation clamps at both ends
  a_r4_sat_high: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && strobe.mode == SCALE_SAT && diffQ > SAT_HI) |=>
      (outData == SAT_HI[OUT_W-1:0]));

  a_r4_sat_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && strobe.mode == SCALE_SAT && diffQ < SAT_LO) |=>
      (outData == SAT_LO[OUT_W-1:0]));

endmodule

// File: rtl/ped_sub_scale.sv
module ped_sub_scale
  import ped_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int OUT_W    = 8,
  parameter int STRIPS   = 32,
  parameter int FRAC_K   = 4,
  localparam int IDX_W   = $clog2(STRIPS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inVld,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [IDX_W-1:0]    inStrip,
  input  logic                pedEn,
  input  logic                trackEn,
  input  logic [1:0]          scaleMode,
  input  logic                hostWe,
  input  logic [IDX_W-1:0]    hostAddr,
  input  logic [SAMPLE_W-1:0] hostWdata,
  output logic [SAMPLE_W-1:0] hostRdata,
  output logic                outVld,
  output logic [OUT_W-1:0]    outData,
  output logic [IDX_W-1:0]    outStrip
);

  stage_strobe_t       strobe;
  logic                trackStep;
  logic [SAMPLE_W-1:0] pedCur;

  ped_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inVld     (inVld),
    .pedEn     (pedEn),
    .trackEn   (trackEn),
    .scaleMode (scaleMode),
    .strobe    (strobe),
    .trackStep (trackStep),
    .outVld    (outVld)
  );

  ped_table #(
    .STRIPS (STRIPS),
    .PED_W  (SAMPLE_W),
    .FRAC_K (FRAC_K)
  ) u_table (
    .clk       (clk),
    .rstN      (rstN),
    .trackStep (trackStep),
    .rdStrip   (inStrip),
    .sample    (inSample),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .pedOut    (pedCur),
    .hostRdata (hostRdata)
  );

  ped_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .OUT_W    (OUT_W),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sample   (inSample),
    .strip    (inStrip),
    .ped      (pedCur),
    .outData  (outData),
    .outStrip (outStrip)
  );

endmodule

// File: tb/ped_sub_scale_test.sv
module ped_sub_scale_test;

  localparam int STRIPS = 32;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inVld;
  logic [9:0] inSample;
  logic [4:0] inStrip;
  logic       pedEn;
  logic       trackEn;
  logic [1:0] scaleMode;
  logic       hostWe;
  logic [4:0] hostAddr;
  logic [9:0] hostWdata;
  logic [9:0] hostRdata;
  logic       outVld;
  logic [7:0] outData;
  logic [4:0] outStrip;

  always #4 clk = ~clk;   // 125 MHz

  ped_sub_scale uut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inSample(inSample), .inStrip(inStrip),
    .pedEn(pedEn), .trackEn(trackEn), .scaleMode(scaleMode),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .outVld(outVld), .outData(outData), .outStrip(outStrip)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;
  int  cyc     = 0;

  // Behavioural reference model
  int         mPed [STRIPS];
  int         mAcc [STRIPS];
  logic [7:0] qData [$];
  logic [4:0] qStrip [$];
  logic       mV1 = 1'b0;
  logic       mV2 = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] scaleRef(input int d, input int m);
    int r;
    if (m == 0) r = (d > 127) ? 127 : ((d < -128) ? -128 : d);
    else        r = d >>> m;
    return 8'(r & 255);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STRIPS; i++) begin mPed[i] = 0; mAcc[i] = 0; end
      qData.delete();
      qStrip.delete();
      mV1 <= 1'b0;
      mV2 <= 1'b0;
    end else begin
      if (inVld) begin
        int p, d, a, np;
        p = mPed[inStrip];
        d = pedEn ? (int'(inSample) - p) : int'(inSample);
        qData.push_back(scaleRef(d, int'(scaleMode)));
        qStrip.push_back(inStrip);
        if (trackEn && !(hostWe && hostAddr == inStrip)) begin
          a = mAcc[inStrip] + int'(inSample) - p;
          np = p;
          if (a >= 8)       begin np = p + 1; a = 0; end
          else if (a <= -8) begin np = p - 1; a = 0; end
          mPed[inStrip] = np;
          mAcc[inStrip] = a;
        end
      end
      if (hostWe) begin
        mPed[hostAddr] = int'(hostWdata);
        mAcc[hostAddr] = 0;
      end
      mV2 <= mV1;
      mV1 <= inVld;
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(outVld === mV2, "R1 valid latency", int'(outVld), int'(mV2));
      if (outVld) begin
        if (qData.size() == 0) begin
          check(1'b0, "R1 unexpected output", 1, 0);
        end else begin
          logic [7:0] e;
          logic [4:0] es;
          e  = qData.pop_front();
          es = qStrip.pop_front();
          check(outData === e, "R2/R3/R4/R5/R11 data", int'(outData), int'(e));
          check(outStrip === es, "R1 strip tag", int'(outStrip), int'(es));
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic drive(input int s, input int v);
    hostWe = 1'b0; inVld = 1'b1; inStrip = 5'(s); inSample = 10'(v);
    @(negedge clk);
  endtask

  task automatic flush();
    inVld = 1'b0; hostWe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic hostWrite(input int a, input int v);
    inVld = 1'b0; hostWe = 1'b1; hostAddr = 5'(a); hostWdata = 10'(v);
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input int a, input int exp, input string req);
    inVld = 1'b0; hostWe = 1'b0; hostAddr = 5'(a);
    @(negedge clk);
    check(hostRdata === 10'(exp), req, int'(hostRdata), exp);
  endtask

  task automatic oneShot(input int s, input int v, input int exp, input string req);
    drive(s, v);
    inVld = 1'b0;
    @(negedge clk);
    check(outVld === 1'b1 && outData === 8'(exp), req, int'(outData), exp);
  endtask

  initial begin
    rstN = 1'b0; inVld = 1'b0; inSample = '0; inStrip = '0;
    pedEn = 1'b1; trackEn = 1'b0; scaleMode = 2'd0;
    hostWe = 1'b0; hostAddr = '0; hostWdata = '0;
    repeat (3) @(negedge clk);
    check(outVld === 1'b0, "R6 reset valid", int'(outVld), 0);
    check(outData === 8'h00, "R6 reset data", int'(outData), 0);
    rstN = 1'b1;
    @(negedge clk);
    hostRead(0, 0, "R6 reset pedestal strip 0");
    hostRead(31, 0, "R6 reset pedestal strip 31");

    // R7: fill and read back the table
    for (int s = 0; s < STRIPS; s++) hostWrite(s, (s * 97 + 11) % 1024);
    hostRead(7, (7 * 97 + 11) % 1024, "R7 readback strip 7");
    hostRead(31, (31 * 97 + 11) % 1024, "R7 readback strip 31");

    // R2/R4/R5: streams in each mode, tracking off
    for (int m = 0; m < 4; m++) begin
      scaleMode = 2'(m);
      flush();
      for (int i = 0; i < 40; i++) drive(i % STRIPS, (i * 211 + m * 37 + 5) % 1024);
      flush();
    end

    // R4 saturation ends, R2 plain difference
    scaleMode = 2'd0;
    hostWrite(5, 1000);
    oneShot(5, 0, 8'h80, "R4 saturate low");
    hostWrite(6, 0);
    oneShot(6, 1023, 8'h7F, "R4 saturate high");
    hostWrite(8, 100);
    oneShot(8, 150, 8'h32, "R2 difference 50");

    // R5 bit windows
    scaleMode = 2'd1; oneShot(6, 1023, 8'hFF, "R5 mode1 bits 8..1");
    scaleMode = 2'd2; oneShot(6, 1023, 8'hFF, "R5 mode2 bits 9..2");
    scaleMode = 2'd3; oneShot(6, 1023, 8'h7F, "R5 mode3 bits 10..3");
    oneShot(5, 0, 8'h83, "R5 mode3 negative");

    // R3 bypass of subtraction
    pedEn = 1'b0;
    oneShot(5, 1023, 8'h7F, "R3 raw mode3");
    scaleMode = 2'd1;
    oneShot(5, 600, 8'h2C, "R3 raw mode1");
    pedEn = 1'b1;
    scaleMode = 2'd0;
    flush();

    // R9/R11 tracking upward and downward, back to back
    trackEn = 1'b1;
    hostWrite(2, 200);
    for (int i = 0; i < 7; i++) drive(2, 203);
    flush();
    hostRead(2, 202, "R9 upward tracking");
    hostWrite(3, 50);
    for (int i = 0; i < 5; i++) drive(3, 0);
    flush();
    hostRead(3, 45, "R9 R11 downward tracking");

    // R10 host write collides with a tracking update
    hostWrite(4, 300);
    drive(4, 305);
    inVld = 1'b1; inStrip = 5'd4; inSample = 10'd305;
    hostWe = 1'b1; hostAddr = 5'd4; hostWdata = 10'd777;
    @(negedge clk);
    hostWe = 1'b0;
    drive(4, 784);
    flush();
    hostRead(4, 777, "R10 host wins and accumulator cleared");

    // R8 tracking off leaves pedestals alone
    trackEn = 1'b0;
    for (int i = 0; i < 10; i++) drive(6, 900);
    flush();
    hostRead(6, 0, "R8 no tracking");

    // Randomised tracking run
    trackEn = 1'b1;
    for (int b = 0; b < 8; b++) begin
      scaleMode = 2'(b % 4);
      pedEn = (b != 5);
      flush();
      for (int i = 0; i < 200; i++) begin
        if ($urandom % 4 != 0) begin
          int s, v;
          s = int'($urandom % 8);
          v = mPed[s] + int'($urandom % 41) - 20;
          if (v < 0) v = 0;
          if (v > 1023) v = 1023;
          drive(s, v);
        end else begin
          inVld = 1'b0;
          @(negedge clk);
        end
      end
      flush();
    end
    pedEn = 1'b1;
    for (int s = 0; s < STRIPS; s++) hostRead(s, mPed[s], "R9 table after random tracking");

    check(qData.size() == 0, "R1 outputs drained", qData.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule